// File: doc/BRIEF.md
# Page Write Load Sequencer

This block sits behind an asynchronous byte-wide memory bus whose chip-enable, write-enable and output-enable strobes (all active low) are sampled on the system clock. A qualified write strobe loads one byte into a page buffer. Bytes keep arriving for as long as each new strobe follows the previous one inside an inactivity window. Once the window lapses, the block enters a fixed-length programming period and raises `busy`. At the end of that period it commits the loaded byte positions to a register array that stands in for the storage cells.

The address splits into a byte offset (the low `PAGE_BITS` bits) and a page number (the remaining upper bits). The first qualified strobe of a load fixes the page. A later byte that names another page is dropped and sets a sticky error flag. A read strobe returns array contents on `dout`. The load timeout, the programming time and the glitch filter length are parameters counted in clock cycles.

Top module: `page_load_seq`

## Requirements
- R1: A write starts only while the sampled chip-enable is low, write-enable is low and output-enable is high. If output-enable is low or chip-enable is high, a write-enable low pulse loads nothing and does not start programming.
- R2: Write-enable must be seen low, with the other two strobes qualifying, on at least `GLITCH_MIN` consecutive clock samples before a write counts. Shorter pulses have no effect. A pulse of exactly `GLITCH_MIN` samples counts.
- R3: The address is taken on the first sampled cycle of the qualifying strobe, and the data on its last sampled low cycle. Byte offset = `addr[PAGE_BITS-1:0]`; page = `addr[ADDR_W-1:PAGE_BITS]`.
- R4: Within one load, a byte whose page differs from the first byte's page is not stored and does not re-arm the timeout. `page_err` goes to 1 and stays at 1 until reset.
- R5: The inactivity timeout restarts at each qualified same-page strobe. Programming starts (`busy` rises) only after `LOAD_TO` cycles pass with no such strobe and no strobe still asserted.
- R6: `busy` stays high for `PROG_CYC` cycles. Any write during that period is ignored and leaves `page_err` untouched.
- R7: When programming ends, only the byte positions loaded in that load are written into the array. All other locations keep their previous contents.
- R8: A single qualified write forms a load of one byte and is programmed without any further bus activity.
- R9: With chip-enable and output-enable both low, `dout` shows the array byte at `addr` two clock edges after the strobe is applied. Otherwise `dout` is 0.
- R10: Reset clears `busy`, `page_err` and the whole array to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address: page number above offset |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, 0 when no read is active |
| busy | output | 1 | High during the programming period |
| page_err | output | 1 | Sticky flag for a byte aimed at another page |

## Verification
A full 128-byte page is loaded with an arithmetic pattern and read back. This shows that every offset maps to its own location. A sparse reload of every fourth offset over that page then shows that unloaded positions survive a commit. Writes spaced just inside the timeout must keep `busy` low between them, and a lone byte must raise it after the window, which separates re-arming from a fixed window. Pulses one sample below and exactly at the glitch length, strobes with output-enable low or chip-enable high, writes made while busy, and a second page inside one load each show that the guarded location stays unchanged, or that it does change when it should.

// File: rtl/page_load_pkg.sv
package page_load_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } seq_state_t;
endpackage

// File: rtl/bus_strobe_filter.sv
module bus_strobe_filter #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int GLITCH_MIN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              bus_active,
  output logic              arm,
  output logic              byte_evt,
  output logic [ADDR_W-1:0] strobe_addr,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [DATA_W-1:0] byte_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int CW = $clog2(GLITCH_MIN + 1);

  logic              ce_s, we_s, oe_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;
  logic [CW-1:0]     low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_s   <= 1'b1;
      we_s   <= 1'b1;
      oe_s   <= 1'b1;
      addr_s <= '0;
      din_s  <= '0;
    end else begin
      ce_s   <= ce_n;
      we_s   <= we_n;
      oe_s   <= oe_n;
      addr_s <= addr;
      din_s  <= din;
    end
  end

  assign bus_active = ~ce_s & ~we_s & oe_s;
  assign rd_en      = ~ce_s & ~oe_s;
  assign rd_addr    = addr_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt   <= '0;
      byte_addr <= '0;
      byte_data <= '0;
    end else if (bus_active) begin
      if (low_cnt == '0) byte_addr <= addr_s;
      if (low_cnt != CW'(GLITCH_MIN)) low_cnt <= low_cnt + 1'b1;
      byte_data <= din_s;
    end else begin
      low_cnt <= '0;
    end
  end

  assign strobe_addr = (low_cnt == '0) ? addr_s : byte_addr;
  assign arm         = bus_active && (low_cnt == CW'(GLITCH_MIN - 1));
  assign byte_evt    = !bus_active && (low_cnt == CW'(GLITCH_MIN));

  AST_BYTE_NEEDS_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    byte_evt |-> $past(oe_s) && !$past(ce_s));  // R1
  AST_BYTE_AFTER_ARM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    byte_evt |-> $past(bus_active));  // R2
endmodule

// File: rtl/load_timer.sv
module load_timer
  import page_load_pkg::*;
#(
  parameter int LOAD_TO  = 1000,
  parameter int PROG_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rearm,
  input  logic bus_active,
  output logic loading,
  output logic busy,
  output logic commit
);
  localparam int MAXC = (LOAD_TO > PROG_CYC) ? LOAD_TO : PROG_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  seq_state_t    state;
  logic [CW-1:0] cnt;
  logic          expire;

  assign loading = (state == ST_LOAD);
  assign busy    = (state == ST_PROG);
  assign expire  = loading && !rearm && (cnt >= CW'(LOAD_TO - 1)) && !bus_active;
  assign commit  = busy && (cnt == CW'(PROG_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_LOAD;
          cnt   <= '0;
        end
        ST_LOAD: begin
          if (rearm)                       cnt <= '0;
          else if (expire) begin
            state <= ST_PROG;
            cnt   <= '0;
          end else if (cnt < CW'(LOAD_TO - 1)) cnt <= cnt + 1'b1;
        end
        ST_PROG: begin
          if (commit) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_PROG_ONLY_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(loading));  // R5
  AST_NO_EXPIRY_MID_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    loading && bus_active |=> !busy);  // R5
endmodule

// File: rtl/page_load_seq.sv
module page_load_seq #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int PAGE_BITS  = 7,
  parameter int GLITCH_MIN = 3,
  parameter int LOAD_TO    = 1000,
  parameter int PROG_CYC   = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              busy,
  output logic              page_err
);
  localparam int PAGE_SZ = 1 << PAGE_BITS;
  localparam int MEM_SZ  = 1 << ADDR_W;
  localparam int PG_W    = ADDR_W - PAGE_BITS;

  function automatic logic [PG_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:PAGE_BITS];
  endfunction

  function automatic logic [PAGE_BITS-1:0] off_of(input logic [ADDR_W-1:0] a);
    return a[PAGE_BITS-1:0];
  endfunction

  logic              bus_active, arm, byte_evt, rd_en, loading, commit;
  logic [ADDR_W-1:0] strobe_addr, byte_addr, rd_addr;
  logic [DATA_W-1:0] byte_data;
  logic [PG_W-1:0]   load_page;
  logic              start_load, rearm, buf_we, page_miss;

  logic [DATA_W-1:0]  buf_data [PAGE_SZ];
  logic [PAGE_SZ-1:0] buf_vld;
  logic [DATA_W-1:0]  mem [MEM_SZ];

  bus_strobe_filter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLITCH_MIN(GLITCH_MIN)) u_filter (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .bus_active(bus_active), .arm(arm), .byte_evt(byte_evt),
    .strobe_addr(strobe_addr), .byte_addr(byte_addr), .byte_data(byte_data),
    .rd_en(rd_en), .rd_addr(rd_addr)
  );

  load_timer #(.LOAD_TO(LOAD_TO), .PROG_CYC(PROG_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start_load), .rearm(rearm),
    .bus_active(bus_active), .loading(loading), .busy(busy), .commit(commit)
  );

  assign start_load = arm && !loading && !busy;
  assign rearm      = arm && loading && (page_of(strobe_addr) == load_page);
  assign buf_we     = byte_evt && loading && (page_of(byte_addr) == load_page);
  assign page_miss  = byte_evt && loading && (page_of(byte_addr) != load_page);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_page <= '0;
      page_err  <= 1'b0;
    end else begin
      if (start_load) load_page <= page_of(strobe_addr);
      if (page_miss)  page_err  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_vld <= '0;
      for (int i = 0; i < PAGE_SZ; i++) buf_data[i] <= '0;
    end else if (commit) begin
      buf_vld <= '0;
    end else if (buf_we) begin
      buf_vld[off_of(byte_addr)]  <= 1'b1;
      buf_data[off_of(byte_addr)] <= byte_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < MEM_SZ; j++) mem[j] <= '0;
    end else if (commit) begin
      for (int i = 0; i < PAGE_SZ; i++)
        if (buf_vld[i]) mem[{load_page, PAGE_BITS'(i)}] <= buf_data[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     dout <= '0;
    else if (rd_en) dout <= mem[rd_addr];
    else            dout <= '0;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err);  // R4
  AST_COMMIT_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);  // R6
  AST_BUF_CLEAR_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (buf_vld == '0));  // R7
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (dout == '0));  // R9
endmodule

// File: tb/page_load_seq_tb.sv
module page_load_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10, DW = 8, PB = 7, GM = 3, LTO = 40, PRG = 60;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic busy, page_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_load_seq #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BITS(PB), .GLITCH_MIN(GM),
                  .LOAD_TO(LTO), .PROG_CYC(PRG)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .busy(busy), .page_err(page_err));

  function automatic logic [AW-1:0] mk(input int pg, input int off);
    return AW'(pg * (1 << PB) + off);
  endfunction
  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input int lows,
                    input logic oe, input logic ce);
    @(negedge clk);
    addr = a; din = d; ce_n = ce; we_n = 1'b0; oe_n = oe;
    repeat (lows) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    repeat (2) @(negedge clk);
    d = dout;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R10 reset state
    chk(busy == 0, "R10 busy after reset", busy, 0);
    chk(page_err == 0, "R10 err after reset", page_err, 0);
    rd(mk(0, 5), v); chk(v == 0, "R10 array cleared", v, 0);
    // R9 idle bus reads zero, oe high
    @(negedge clk); addr = mk(0, 5); ce_n = 0; oe_n = 1; idle(3);
    chk(dout == 0, "R9 dout zero without oe", dout, 0);
    ce_n = 1; idle(1);

    // R8 single byte, R5 timeout, R6 busy length
    wr(mk(0, 5), 8'h3C, 4, 1'b1, 1'b0);
    idle(LTO - 15);
    chk(busy == 0, "R5 busy before timeout", busy, 0);
    idle(20);
    chk(busy == 1, "R5 busy after timeout", busy, 1);
    idle(PRG - 15);
    chk(busy == 1, "R6 busy held during program", busy, 1);
    idle(25);
    chk(busy == 0, "R6 busy released", busy, 0);
    rd(mk(0, 5), v); chk(v == 8'h3C, "R8 single byte committed", v, 8'h3C);

    // R3 full page sweep on page 3
    for (int i = 0; i < (1 << PB); i++) begin
      wr(mk(3, i), pat(i), 4, 1'b1, 1'b0);
      idle(4);
      if (i == 64) chk(busy == 0, "R5 no expiry inside page load", busy, 0);
    end
    idle(LTO + PRG + 20);
    for (int i = 0; i < (1 << PB); i++) begin
      rd(mk(3, i), v);
      chk(v == pat(i), "R3 page byte readback", v, pat(i));
    end
    rd(mk(2, 127), v); chk(v == 0, "R7 neighbour page below untouched", v, 0);
    rd(mk(4, 0), v);   chk(v == 0, "R7 neighbour page above untouched", v, 0);

    // R7 sparse reload: only loaded offsets change
    for (int i = 0; i < (1 << PB); i += 4) begin
      wr(mk(3, i), ~pat(i), 4, 1'b1, 1'b0);
      idle(4);
    end
    idle(LTO + PRG + 20);
    for (int i = 0; i < (1 << PB); i++) begin
      logic [7:0] e;
      e = (i % 4 == 0) ? ~pat(i) : pat(i);
      rd(mk(3, i), v);
      chk(v == e, "R7 sparse commit", v, e);
    end

    // R5 re-arm: writes spaced just inside the window
    for (int k = 0; k < 3; k++) begin
      wr(mk(5, k), 8'h50 + 8'(k), 4, 1'b1, 1'b0);
      idle(LTO - 15);
      chk(busy == 0, "R5 timeout re-armed by strobe", busy, 0);
    end
    idle(LTO + PRG + 20);
    for (int k = 0; k < 3; k++) begin
      rd(mk(5, k), v);
      chk(v == 8'h50 + 8'(k), "R5 spaced bytes committed", v, 8'h50 + k);
    end

    // R2 glitch below and at threshold
    wr(mk(6, 1), 8'hA1, GM - 1, 1'b1, 1'b0);
    idle(LTO + 10);
    chk(busy == 0, "R2 short pulse starts nothing", busy, 0);
    rd(mk(6, 1), v); chk(v == 0, "R2 short pulse stores nothing", v, 0);
    wr(mk(6, 2), 8'hA2, GM, 1'b1, 1'b0);
    idle(LTO + PRG + 20);
    rd(mk(6, 2), v); chk(v == 8'hA2, "R2 pulse at threshold stored", v, 8'hA2);

    // R1 inhibit: oe low, ce high
    wr(mk(6, 3), 8'hB3, 6, 1'b0, 1'b0);
    idle(LTO + 10);
    chk(busy == 0, "R1 oe low blocks program", busy, 0);
    rd(mk(6, 3), v); chk(v == 0, "R1 oe low blocks store", v, 0);
    wr(mk(6, 4), 8'hB4, 6, 1'b1, 1'b1);
    idle(LTO + 10);
    chk(busy == 0, "R1 ce high blocks program", busy, 0);
    rd(mk(6, 4), v); chk(v == 0, "R1 ce high blocks store", v, 0);

    // R6 writes ignored while busy
    wr(mk(7, 1), 8'h71, 4, 1'b1, 1'b0);
    idle(LTO + 5);
    chk(busy == 1, "R6 programming entered", busy, 1);
    wr(mk(7, 9), 8'h79, 4, 1'b1, 1'b0);
    wr(mk(1, 9), 8'h19, 4, 1'b1, 1'b0);
    idle(PRG + LTO + 20);
    rd(mk(7, 9), v); chk(v == 0, "R6 write during busy ignored", v, 0);
    rd(mk(7, 1), v); chk(v == 8'h71, "R6 prior byte committed", v, 8'h71);
    chk(page_err == 0, "R6 busy write no error", page_err, 0);

    // R4 page rule
    wr(mk(1, 2), 8'h12, 4, 1'b1, 1'b0);
    idle(4);
    wr(mk(2, 2), 8'h22, 4, 1'b1, 1'b0);
    idle(3);
    chk(page_err == 1, "R4 error on page mismatch", page_err, 1);
    idle(LTO + PRG + 20);
    rd(mk(1, 2), v); chk(v == 8'h12, "R4 first page byte kept", v, 8'h12);
    rd(mk(2, 2), v); chk(v == 0, "R4 other page byte dropped", v, 0);
    chk(page_err == 1, "R4 error sticky", page_err, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule